// File: doc/BRIEF.md
# Display PLL Output Clock Tree

This block takes one fast VCO clock and turns it into two derived clocks for a display serial link: a byte clock and a pixel clock. The pixel clock comes from a programmable divider that runs directly on the VCO. The byte clock can come from either of two sources. The first source is the raw VCO. The second is an indirect path: a programmable post-divider followed by a fixed divide-by-two stage. A fixed divide-by-four stage follows whichever source is chosen.

The divider fields and the path select sit in three small registers. They are written and read back through an address/data/write-strobe port that runs on the VCO clock. Each divided output is a registered level and changes on the rising edge of `vco_clk`. A new divider value is loaded only when the divider's current output period ends.

Top module: `pll_clk_tree`

## Requirements
- R1: While `rst_n` is low, `byte_clk` is low and all three configuration fields read back as zero. In that state the pixel ratio is 1, the post ratio is 1 and the byte clock uses the raw path.
- R2: Register map (8-bit data). Address 0 holds the pixel field in bits 7:0. Address 1 holds the post field in bits 3:0, and bits 7:4 read as zero. Address 2 holds the path select in bit 1, and its other bits read as zero. Address 3 reads as zero, and a write to it changes nothing. A write takes effect on the `vco_clk` edge that samples `cfg_we` high. `cfg_rdata` follows `cfg_addr` without delay.
- R3: With a pixel field F of 1 or more, the period of `pix_clk` is F+1 VCO cycles. The high phase lasts ceil((F+1)/2) cycles and the low phase lasts floor((F+1)/2) cycles.
- R4: With a pixel field of 0, `pix_clk` follows `vco_clk` undivided.
- R5: With the select bit at 0 (raw path), the period of `byte_clk` is 4 VCO cycles: 2 cycles high, then 2 cycles low.
- R6: With the select bit at 1 (indirect path) and a post field G, the period of `byte_clk` is 8*(G+1) VCO cycles, split equally between high and low.
- R7: When the pixel field is written in the middle of a `pix_clk` period, that period completes with its old high and low lengths. The new ratio applies from the next period.
- R8: After `rst_n` is released, `byte_clk` is high following the first `vco_clk` rising edge. It then follows the raw-path pattern of 2 cycles high and 2 cycles low, so every divider starts a fresh period together.

Port list, in the order of the top module's declaration:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; clocks every register of the block |
| rst_n | input | 1 | Asynchronous active-low reset for the counters and the registers |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| byte_clk | output | 1 | Byte clock: the selected source divided by four |
| pix_clk | output | 1 | Pixel clock: the VCO divided by the pixel ratio |

## Verification
Suppose a divider counter holds a wrong value or latches its ratio at the wrong moment. The fault then appears as a wrong high or low run length on `pix_clk` or `byte_clk`, and it is visible within one output period: at most 256 VCO cycles on the pixel side and 128 on the byte side. A wrong state in the divide-by-two stage or the path select doubles or halves the byte period within one byte period. A corrupted register field appears at once on `cfg_rdata`, and it shows in the output periods from the next period boundary. The bench measures run lengths edge by edge and checks that a mid-period rewrite leaves the current period unchanged.

// File: rtl/pll_clk_tree_pkg.sv
package pll_clk_tree_pkg;

    localparam int PIX_W    = 8;
    localparam int POST_W   = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int BYTE_DIV = 4;
    localparam int BYTE_W   = $clog2(BYTE_DIV);
    localparam int SEL_BIT  = 1;

    localparam logic [ADDR_W-1:0] A_PIX  = 2'd0;
    localparam logic [ADDR_W-1:0] A_POST = 2'd1;
    localparam logic [ADDR_W-1:0] A_PATH = 2'd2;

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [POST_W-1:0] post;
        logic              sel;
    } tree_cfg_t;

endpackage

// File: rtl/ptree_div.sv
// Programmable divider: ratio_m1+1 advance pulses per output period.
// High phase is ceil(ratio/2), low phase floor(ratio/2).
// A new ratio is loaded only at the wrap that ends the current period.
module ptree_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] ratio_m1,
    output logic         lvl,
    output logic         wrap,
    output logic         unity
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] act;
        logic         lvl;
    } div_state_t;

    localparam logic [W:0] TWO = (W+1)'(2);

    div_state_t s_d, s_q;
    logic [W:0] hi_len;

    always_comb begin
        s_d    = s_q;
        hi_len = '0;
        wrap   = adv && (s_q.cnt == s_q.act);
        if (adv) begin
            if (wrap) begin
                s_d.cnt = '0;
                s_d.act = ratio_m1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            hi_len  = ({1'b0, s_d.act} + TWO) >> 1;
            s_d.lvl = ({1'b0, s_d.cnt} < hi_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl   = s_q.lvl;
    assign unity = (s_q.act == '0);
endmodule

// File: rtl/ptree_cfg_regs.sv
module ptree_cfg_regs
    import pll_clk_tree_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output tree_cfg_t         cfg
);
    tree_cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                A_PIX:   r_d.pix  = wdata[PIX_W-1:0];
                A_POST:  r_d.post = wdata[POST_W-1:0];
                A_PATH:  r_d.sel  = wdata[SEL_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_PIX:   rdata = DATA_W'(r_q.pix);
            A_POST:  rdata = DATA_W'(r_q.post);
            A_PATH:  rdata[SEL_BIT] = r_q.sel;
            default: rdata = '0;
        endcase
    end

    assign cfg = r_q;
endmodule

// File: rtl/pll_clk_tree.sv
module pll_clk_tree
    import pll_clk_tree_pkg::*;
(
    input  logic              vco_clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              byte_clk,
    output logic              pix_clk
);
    localparam logic [BYTE_W-1:0] BYTE_M1 = BYTE_W'(BYTE_DIV - 1);

    tree_cfg_t cfg;
    logic post_wrap, half_d, half_q, byte_tick;
    logic byte_lvl, pix_lvl, pix_unity;
    logic post_lvl_unused, post_unity_unused;
    logic byte_wrap_unused, byte_unity_unused, pix_wrap_unused;

    ptree_cfg_regs u_regs (
        .clk   (vco_clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Indirect path: programmable post-divider on the VCO.
    ptree_div #(.W(POST_W)) u_post (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .adv      (1'b1),
        .ratio_m1 (cfg.post),
        .lvl      (post_lvl_unused),
        .wrap     (post_wrap),
        .unity    (post_unity_unused)
    );

    // Fixed divide-by-two: toggles once per post-divider period.
    // Path select: raw VCO gives one source edge per cycle; the indirect
    // path gives one source edge per rising edge of the halved clock.
    always_comb begin
        half_d    = half_q ^ post_wrap;
        byte_tick = cfg.sel ? (post_wrap & ~half_q) : 1'b1;
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
    end

    // Fixed divide-by-four on the selected source.
    ptree_div #(.W(BYTE_W)) u_byte (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .adv      (byte_tick),
        .ratio_m1 (BYTE_M1),
        .lvl      (byte_lvl),
        .wrap     (byte_wrap_unused),
        .unity    (byte_unity_unused)
    );

    // Pixel divider straight on the VCO.
    ptree_div #(.W(PIX_W)) u_pix (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .adv      (1'b1),
        .ratio_m1 (cfg.pix),
        .lvl      (pix_lvl),
        .wrap     (pix_wrap_unused),
        .unity    (pix_unity)
    );

    assign byte_clk = byte_lvl;
    assign pix_clk  = pix_unity ? vco_clk : pix_lvl;
endmodule

// File: rtl/ptree_chk.sv
module ptree_chk
    import pll_clk_tree_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              pix_lvl,
    input logic              pix_unity,
    input logic              byte_clk
);
    localparam int PIX_RUN_MAX  = (1 << (PIX_W - 1)) + 1;
    localparam int BYTE_RUN_MAX = 4 * (1 << POST_W) + 4;

    logic [15:0] pix_run_q, byte_run_q;
    logic        pix_prev_q, byte_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_run_q   <= '0;
            byte_run_q  <= '0;
            pix_prev_q  <= 1'b0;
            byte_prev_q <= 1'b0;
        end else begin
            pix_prev_q  <= pix_lvl;
            byte_prev_q <= byte_clk;
            if (pix_unity)               pix_run_q <= '0;
            else if (pix_lvl != pix_prev_q) pix_run_q <= 16'd1;
            else if (pix_run_q != '1)    pix_run_q <= pix_run_q + 16'd1;
            if (byte_clk != byte_prev_q) byte_run_q <= 16'd1;
            else if (byte_run_q != '1)   byte_run_q <= byte_run_q + 16'd1;
        end
    end

    // R2: read data only moves after a write or an address change
    p_readback_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ((cfg_rdata == $past(cfg_rdata)) || (cfg_addr != $past(cfg_addr))));

    // R2: the unmapped address always reads zero
    p_spare_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd3) |-> (cfg_rdata == '0));

    // R3: no pixel phase outlasts half the largest ratio
    p_pix_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_run_q <= 16'(PIX_RUN_MAX));

    // R6: no byte phase outlasts half the longest indirect period
    p_byte_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_run_q <= 16'(BYTE_RUN_MAX));
endmodule

bind pll_clk_tree ptree_chk u_chk (
    .clk       (vco_clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .pix_lvl   (pix_lvl),
    .pix_unity (pix_unity),
    .byte_clk  (byte_clk)
);

// File: tb/pll_clk_tree_test.sv
module pll_clk_tree_test;
    localparam int CLK_PERIOD = 10;

    logic       vco_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       cfg_we  = 1'b0;
    logic [1:0] cfg_addr  = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       byte_clk, pix_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pll_clk_tree uut (
        .vco_clk   (vco_clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .byte_clk  (byte_clk),
        .pix_clk   (pix_clk)
    );

    always #(CLK_PERIOD/2) vco_clk = ~vco_clk;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge vco_clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge vco_clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge vco_clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic step(input bit use_byte, output logic v);
        @(posedge vco_clk);
        #1 v = use_byte ? byte_clk : pix_clk;
    endtask

    // Syncs to a rising edge, counts one high and one low run; ends on the next rise.
    task automatic measure(input bit use_byte, output int hi, output int lo);
        logic cur, prv;
        step(use_byte, cur);
        do begin prv = cur; step(use_byte, cur); end while (!(prv == 1'b0 && cur == 1'b1));
        hi = 0;
        while (cur == 1'b1) begin hi++; step(use_byte, cur); end
        lo = 0;
        while (cur == 1'b0) begin lo++; step(use_byte, cur); end
    endtask

    task automatic t_reset_and_start();
        logic [7:0] d;
        logic v;
        @(negedge vco_clk);
        rst_n = 1'b0;
        repeat (2) @(negedge vco_clk);
        #1 chk("R1 byte_clk low in reset", int'(byte_clk), 0);
        for (int a = 0; a < 3; a++) begin
            read_reg(2'(a), d);
            chk($sformatf("R1 reg %0d zero in reset", a), int'(d), 0);
        end
        @(negedge vco_clk);
        rst_n = 1'b1;
        step(1'b1, v); chk("R8 byte after edge 1", int'(v), 1);
        step(1'b1, v); chk("R8 byte after edge 2", int'(v), 1);
        step(1'b1, v); chk("R8 byte after edge 3", int'(v), 0);
        step(1'b1, v); chk("R8 byte after edge 4", int'(v), 0);
        step(1'b1, v); chk("R8 byte after edge 5", int'(v), 1);
    endtask

    task automatic t_pix_bypass();
        for (int i = 0; i < 3; i++) begin
            @(posedge vco_clk); #1 chk("R4 pix follows vco high", int'(pix_clk), 1);
            @(negedge vco_clk); #1 chk("R4 pix follows vco low", int'(pix_clk), 0);
        end
    endtask

    task automatic t_regs();
        logic [7:0] d;
        write_reg(2'd0, 8'hA5); read_reg(2'd0, d); chk("R2 pixel field", int'(d), 'hA5);
        write_reg(2'd1, 8'hFF); read_reg(2'd1, d); chk("R2 post field 4 bits", int'(d), 'h0F);
        write_reg(2'd2, 8'hFF); read_reg(2'd2, d); chk("R2 select bit 1 only", int'(d), 'h02);
        write_reg(2'd3, 8'h3C); read_reg(2'd3, d); chk("R2 spare address reads 0", int'(d), 0);
        read_reg(2'd0, d); chk("R2 spare write leaves pixel", int'(d), 'hA5);
        read_reg(2'd1, d); chk("R2 spare write leaves post", int'(d), 'h0F);
        read_reg(2'd2, d); chk("R2 spare write leaves select", int'(d), 'h02);
        write_reg(2'd2, 8'h00);
        write_reg(2'd1, 8'h00);
    endtask

    task automatic t_pix_ratio(input int ratio);
        int hi, lo;
        write_reg(2'd0, 8'(ratio - 1));
        measure(1'b0, hi, lo);
        measure(1'b0, hi, lo);
        chk($sformatf("R3 pix high ratio %0d", ratio), hi, (ratio + 1) / 2);
        chk($sformatf("R3 pix low ratio %0d", ratio), lo, ratio / 2);
    endtask

    task automatic t_byte_raw();
        int hi, lo;
        write_reg(2'd2, 8'h00);
        measure(1'b1, hi, lo);
        measure(1'b1, hi, lo);
        chk("R5 byte high raw", hi, 2);
        chk("R5 byte low raw", lo, 2);
    endtask

    task automatic t_byte_indirect(input int post_ratio);
        int hi, lo;
        write_reg(2'd1, 8'(post_ratio - 1));
        write_reg(2'd2, 8'h02);
        measure(1'b1, hi, lo);
        measure(1'b1, hi, lo);
        chk($sformatf("R6 byte high post %0d", post_ratio), hi, 4 * post_ratio);
        chk($sformatf("R6 byte low post %0d", post_ratio), lo, 4 * post_ratio);
    endtask

    task automatic t_boundary();
        int hi, lo, hi2, lo2;
        logic cur;
        write_reg(2'd0, 8'd7);
        measure(1'b0, hi, lo);
        measure(1'b0, hi, lo);
        // Now one sample past a rise of an 8-cycle period; rewrite to ratio 2 mid-phase.
        cur = 1'b1;
        hi = 0; lo = 0; hi2 = 0; lo2 = 0;
        fork
            write_reg(2'd0, 8'd1);
            begin
                while (cur == 1'b1) begin hi++; step(1'b0, cur); end
                while (cur == 1'b0) begin lo++; step(1'b0, cur); end
                while (cur == 1'b1) begin hi2++; step(1'b0, cur); end
                while (cur == 1'b0) begin lo2++; step(1'b0, cur); end
            end
        join
        chk("R7 current period keeps high", hi, 4);
        chk("R7 current period keeps low", lo, 4);
        chk("R7 next period high uses new ratio", hi2, 1);
        chk("R7 next period low uses new ratio", lo2, 1);
    endtask

    initial begin
        repeat (150000) @(posedge vco_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_and_start();
        t_pix_bypass();
        t_regs();
        t_pix_ratio(2);
        t_pix_ratio(5);
        t_pix_ratio(8);
        t_pix_ratio(256);
        t_byte_raw();
        t_byte_indirect(1);
        t_byte_indirect(3);
        t_byte_indirect(16);
        t_byte_raw();
        t_boundary();
        t_reset_and_start();
        t_pix_bypass();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule